// File: doc/BRIEF.md
# Dual-Width ALU Condition-Code Generator

This block is a purely combinational integer ALU. It works on 64-bit operands and produces two flag sets for every operation. The narrow set describes the low 32 bits of the operation. The wide set describes all 64 bits. Both sets come from the same single pass through the datapath, so a following branch unit can test either width without running the operation again.

The caller supplies:
- a 6-bit operation code;
- two 64-bit operands;
- the current carry bit of the narrow flag set.

The carry-consuming operations (add with carry, subtract with borrow) take that narrow carry bit as their carry-in for both widths. Subtraction is computed as A + ~B + 1, and its carry flags are the inverted carry-outs, so C reads as a borrow.

An operation code that is not recognised drives the result and all flags to zero and lowers `flagWrite`. The surrounding flag register therefore keeps its previous contents.

Top module: `alu_cc_gen`

## Requirements
- R1: The operation codes are 0x10 add, 0x11 AND, 0x12 OR, 0x13 XOR, 0x14 subtract, 0x15 AND-NOT (A & ~B), 0x16 OR-NOT (A | ~B), 0x18 add with carry and 0x1C subtract with borrow. For these codes `flagWrite` is 1. For any other code `result`, `iccFlags` and `xccFlags` are all zero and `flagWrite` is 0.
- R2: Each flag vector is packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. N is result bit 31 in `iccFlags` and result bit 63 in `xccFlags`.
- R3: Z is set in `iccFlags` when result bits 31..0 are all zero. Z is set in `xccFlags` when all 64 result bits are zero.
- R4: For add, the result is A + B modulo 2^64. The icc C is the carry out of the 32-bit sum of the low halves. The xcc C is the carry out of bit 63.
- R5: For add and add with carry, V is set when A and B have equal sign bits and the result sign bit differs from them. This is tested at bit 31 for icc and at bit 63 for xcc.
- R6: Add with carry computes A + B + `carryIn`. The same carry-in feeds both the 32-bit and the 64-bit carry chains.
- R7: For subtract, the result is A - B. At each width, C is the complement of the carry out of A + ~B + 1 at that width, which is a borrow.
- R8: For subtract and subtract with borrow, V is set when A and B have different sign bits and the result sign bit differs from the sign bit of A. This is tested at bit 31 and at bit 63.
- R9: Subtract with borrow computes A + ~(B + `carryIn`) + 1. The sum B + `carryIn` wraps modulo 2^64, so B = all ones with `carryIn` = 1 gives result A and C = 0 at both widths. C is the complement of the carry out at each width.
- R10: The five logical operations give the bitwise result. V and C are 0 at both widths.
- R11: `carryIn` has no effect on add, subtract or the logical operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 6 | Operation code |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| carryIn | input | 1 | Current narrow-set carry flag |
| result | output | 64 | Operation result |
| iccFlags | output | 4 | Narrow flags {N,Z,V,C} over bits 31..0 |
| xccFlags | output | 4 | Wide flags {N,Z,V,C} over bits 63..0 |
| flagWrite | output | 1 | High when the code is recognised and the flags should be stored |

## Verification
The hardest case to reach is the one where the two widths disagree.

Random operands almost never produce a carry or overflow at bit 31 without the matching event at bit 63, or the reverse. The stimulus therefore places operands directly on the boundaries:
- 0x7FFFFFFF + 1 and 0xFFFFFFFF + 1, which give narrow overflow and narrow carry only;
- all-ones + 1, which carries at both widths;
- low halves of zero under non-zero high halves, which give narrow Z only.

The wrap of B + carry in subtract with borrow is reached with B = all ones and `carryIn` = 1.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OP_ADD  = 6'h10;
  localparam logic [OP_W-1:0] OP_AND  = 6'h11;
  localparam logic [OP_W-1:0] OP_OR   = 6'h12;
  localparam logic [OP_W-1:0] OP_XOR  = 6'h13;
  localparam logic [OP_W-1:0] OP_SUB  = 6'h14;
  localparam logic [OP_W-1:0] OP_ANDN = 6'h15;
  localparam logic [OP_W-1:0] OP_ORN  = 6'h16;
  localparam logic [OP_W-1:0] OP_ADDC = 6'h18;
  localparam logic [OP_W-1:0] OP_SUBC = 6'h1C;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_OR   = 3'd1,
    LG_XOR  = 3'd2,
    LG_ANDN = 3'd3,
    LG_ORN  = 3'd4
  } logicSel_e;

  // Strobes passed from the decoder to the datapath
  typedef struct packed {
    logic      valid;     // recognised operation
    logic      arith;     // adder path, otherwise logic path
    logic      invertB;   // subtract family: feed ~operand, carry-in 1
    logic      useCarry;  // consume carryIn
    logicSel_e lsel;      // logic function
  } aluCtrl_t;

  // Flag vector bit positions
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_V = 1;
  localparam int FL_C = 0;

endpackage

// File: rtl/alu_cc_ctrl.sv
module alu_cc_ctrl
  import alu_cc_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{valid: 1'b1, arith: 1'b0, invertB: 1'b0, useCarry: 1'b0, lsel: LG_AND};
    case (opSel)
      OP_ADD:  ctrl.arith = 1'b1;
      OP_ADDC: begin ctrl.arith = 1'b1; ctrl.useCarry = 1'b1; end
      OP_SUB:  begin ctrl.arith = 1'b1; ctrl.invertB = 1'b1; end
      OP_SUBC: begin ctrl.arith = 1'b1; ctrl.invertB = 1'b1; ctrl.useCarry = 1'b1; end
      OP_AND:  ctrl.lsel = LG_AND;
      OP_OR:   ctrl.lsel = LG_OR;
      OP_XOR:  ctrl.lsel = LG_XOR;
      OP_ANDN: ctrl.lsel = LG_ANDN;
      OP_ORN:  ctrl.lsel = LG_ORN;
      default: ctrl.valid = 1'b0;
    endcase

    // R1
    strobe_scope_chk: assert (ctrl.valid || !(ctrl.arith || ctrl.invertB || ctrl.useCarry));
    // R11
    carry_arith_only_chk: assert (!ctrl.useCarry || ctrl.arith);
  end

endmodule

// File: rtl/alu_cc_dp.sv
module alu_cc_dp
  import alu_cc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        iccFlags,
  output logic [3:0]        xccFlags
);

  localparam int WIDE_MSB   = DATA_W - 1;
  localparam int NARROW_MSB = NARROW_W - 1;

  logic              cinBit;
  logic              addIn;
  logic [DATA_W-1:0] bAdj;
  logic [DATA_W-1:0] bOp;
  logic [DATA_W:0]   wideSum;
  logic [NARROW_W:0] narrowSum;
  logic [DATA_W-1:0] logicRes;
  logic              wideV, narrowV;
  logic              wideC, narrowC;

  always_comb begin
    cinBit = ctrl.useCarry & carryIn;
    // subtract with borrow folds the carry into B before inversion
    bAdj   = opB + (ctrl.invertB ? DATA_W'(cinBit) : '0);
    bOp    = ctrl.invertB ? ~bAdj : opB;
    addIn  = ctrl.invertB ? 1'b1 : cinBit;

    wideSum   = {1'b0, opA} + {1'b0, bOp} + (DATA_W + 1)'(addIn);
    narrowSum = {1'b0, opA[NARROW_MSB:0]} + {1'b0, bOp[NARROW_MSB:0]}
              + (NARROW_W + 1)'(addIn);

    wideC   = ctrl.invertB ? ~wideSum[DATA_W]     : wideSum[DATA_W];
    narrowC = ctrl.invertB ? ~narrowSum[NARROW_W] : narrowSum[NARROW_W];

    if (ctrl.invertB) begin
      wideV   = (opA[WIDE_MSB] != opB[WIDE_MSB])
             && (wideSum[WIDE_MSB] != opA[WIDE_MSB]);
      narrowV = (opA[NARROW_MSB] != opB[NARROW_MSB])
             && (wideSum[NARROW_MSB] != opA[NARROW_MSB]);
    end else begin
      wideV   = (opA[WIDE_MSB] == opB[WIDE_MSB])
             && (wideSum[WIDE_MSB] != opB[WIDE_MSB]);
      narrowV = (opA[NARROW_MSB] == opB[NARROW_MSB])
             && (wideSum[NARROW_MSB] != opB[NARROW_MSB]);
    end

    case (ctrl.lsel)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      LG_ANDN: logicRes = opA & ~opB;
      LG_ORN:  logicRes = opA | ~opB;
      default: logicRes = '0;
    endcase

    if (!ctrl.valid)     result = '0;
    else if (ctrl.arith) result = wideSum[WIDE_MSB:0];
    else                 result = logicRes;

    iccFlags = '0;
    xccFlags = '0;
    if (ctrl.valid) begin
      iccFlags[FL_N] = result[NARROW_MSB];
      iccFlags[FL_Z] = (result[NARROW_MSB:0] == '0);
      iccFlags[FL_V] = ctrl.arith & narrowV;
      iccFlags[FL_C] = ctrl.arith & narrowC;
      xccFlags[FL_N] = result[WIDE_MSB];
      xccFlags[FL_Z] = (result == '0);
      xccFlags[FL_V] = ctrl.arith & wideV;
      xccFlags[FL_C] = ctrl.arith & wideC;
    end

    // R10
    if (ctrl.valid && !ctrl.arith)
      logic_vc_clear_chk: assert (iccFlags[1:0] == 2'b00 && xccFlags[1:0] == 2'b00);
    // R3
    wide_zero_narrow_chk: assert (!(xccFlags[FL_Z] && !iccFlags[FL_Z]));
    // R1
    if (!ctrl.valid)
      unknown_op_quiet_chk: assert (result == '0 && iccFlags == '0 && xccFlags == '0);
    // R7
    if (ctrl.valid && ctrl.invertB && !ctrl.useCarry && opA == opB)
      sub_equal_no_borrow_chk: assert (iccFlags[FL_Z] && xccFlags[FL_Z]
                                       && !iccFlags[FL_C] && !xccFlags[FL_C]);
  end

endmodule

// File: rtl/alu_cc_gen.sv
module alu_cc_gen
  import alu_cc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [5:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        iccFlags,
  output logic [3:0]        xccFlags,
  output logic              flagWrite
);

  aluCtrl_t ctrl;

  alu_cc_ctrl ctrl_i (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu_cc_dp #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W)
  ) dp_i (
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .result   (result),
    .iccFlags (iccFlags),
    .xccFlags (xccFlags)
  );

  assign flagWrite = ctrl.valid;

endmodule

// File: tb/alu_cc_gen_tb_top.sv
module alu_cc_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opSel = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [63:0] result;
  logic [3:0]  iccFlags;
  logic [3:0]  xccFlags;
  logic        flagWrite;

  always #5 clk = ~clk;

  alu_cc_gen dut_i (
    .opSel     (opSel),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .result    (result),
    .iccFlags  (iccFlags),
    .xccFlags  (xccFlags),
    .flagWrite (flagWrite)
  );

  typedef struct {
    logic [63:0] res;
    logic [3:0]  icc;
    logic [3:0]  xcc;
    logic        fw;
    string       req;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  // Reference model built from the requirement text
  function automatic item_t model(input logic [5:0] op, input logic [63:0] a,
                                  input logic [63:0] b, input logic cin, input string req);
    item_t it;
    logic [64:0] s65;
    logic [32:0] s33;
    logic signed [65:0] sw;
    logic signed [33:0] sn;
    logic [63:0] t;
    logic v32, v64, c32, c64;
    logic cc;
    it.req = req;
    it.fw = 1'b1;
    v32 = 0; v64 = 0; c32 = 0; c64 = 0;
    case (op)
      6'h10, 6'h18: begin
        cc  = (op == 6'h18) ? cin : 1'b0;
        s65 = {1'b0, a} + {1'b0, b} + {64'd0, cc};
        s33 = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'd0, cc};
        it.res = s65[63:0];
        c64 = s65[64];
        c32 = s33[32];
        sw  = $signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b}) + $signed({65'd0, cc});
        sn  = $signed({{2{a[31]}}, a[31:0]}) + $signed({{2{b[31]}}, b[31:0]}) + $signed({33'd0, cc});
        v64 = (sw[64] != sw[63]);
        v32 = (sn[32] != sn[31]);
      end
      6'h14: begin
        it.res = a - b;
        c64 = (a < b);
        c32 = (a[31:0] < b[31:0]);
        sw  = $signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b});
        sn  = $signed({{2{a[31]}}, a[31:0]}) - $signed({{2{b[31]}}, b[31:0]});
        v64 = (sw[64] != sw[63]);
        v32 = (sn[32] != sn[31]);
      end
      6'h1C: begin
        t = b + {63'd0, cin};
        it.res = a - t;
        c64 = (a < t);
        c32 = (a[31:0] < t[31:0]);
        v64 = (a[63] != b[63]) && (it.res[63] != a[63]);
        v32 = (a[31] != b[31]) && (it.res[31] != a[31]);
      end
      6'h11: it.res = a & b;
      6'h12: it.res = a | b;
      6'h13: it.res = a ^ b;
      6'h15: it.res = a & ~b;
      6'h16: it.res = a | ~b;
      default: begin
        it.res = '0;
        it.fw  = 1'b0;
      end
    endcase
    if (it.fw) begin
      it.icc = {it.res[31], it.res[31:0] == 32'd0, v32, c32};
      it.xcc = {it.res[63], it.res == 64'd0, v64, c64};
    end else begin
      it.icc = '0;
      it.xcc = '0;
    end
    return it;
  endfunction

  // Driver: apply stimulus on a rising edge and queue the expectation
  task automatic drive(input logic [5:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic cin, input string req);
    @(posedge clk);
    opSel   = op;
    opA     = a;
    opB     = b;
    carryIn = cin;
    sbq.push_back(model(op, a, b, cin, req));
  endtask

  // Monitor: compare at the falling edge after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t e;
        e = sbq.pop_front();
        checks++;
        if (result !== e.res || iccFlags !== e.icc || xccFlags !== e.xcc || flagWrite !== e.fw) begin
          fails++;
          $display("FAIL %s: op=%h got res=%h icc=%b xcc=%b fw=%b exp res=%h icc=%b xcc=%b fw=%b",
                   e.req, opSel, result, iccFlags, xccFlags, flagWrite,
                   e.res, e.icc, e.xcc, e.fw);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] validOps [9];
    validOps = '{6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h16, 6'h18, 6'h1C};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state, unknown code 0 with zero inputs: R1
    drive(6'h00, 64'd0, 64'd0, 1'b0, "R1 reset");
    // add corners: R4 R5 R2 R3
    drive(6'h10, 64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0, "R5 narrow overflow only");
    drive(6'h10, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, "R4 narrow carry only, R3 narrow Z");
    drive(6'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, "R4 carry both, R3 Z both");
    drive(6'h10, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, "R5 wide overflow, R2 N");
    drive(6'h10, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 1'b0, "R5 negative overflow both");
    // R11: carryIn ignored by add
    drive(6'h10, 64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1, "R11 add ignores carryIn");
    // R6: add with carry
    drive(6'h18, 64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1, "R6 carry into narrow chain");
    drive(6'h18, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 1'b1, "R6 carry into wide chain");
    drive(6'h18, 64'd5, 64'd7, 1'b0, "R6 carry clear");
    // subtract: R7 R8
    drive(6'h14, 64'h1234, 64'h1234, 1'b0, "R7 equal operands");
    drive(6'h14, 64'd0, 64'd1, 1'b0, "R7 borrow both");
    drive(6'h14, 64'h1_0000_0000, 64'd1, 1'b0, "R7 narrow borrow only");
    drive(6'h14, 64'h0000_0000_8000_0000, 64'd1, 1'b0, "R8 narrow overflow");
    drive(6'h14, 64'h8000_0000_0000_0000, 64'd1, 1'b0, "R8 wide overflow");
    drive(6'h14, 64'd3, 64'd10, 1'b1, "R11 sub ignores carryIn");
    // subtract with borrow: R9
    drive(6'h1C, 64'd10, 64'd3, 1'b1, "R9 borrow in");
    drive(6'h1C, 64'd10, 64'd3, 1'b0, "R9 no borrow in");
    drive(6'h1C, 64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R9 wrap of B plus carry");
    drive(6'h1C, 64'd0, 64'd0, 1'b1, "R9 borrow from zero");
    // logic: R10 R11
    drive(6'h11, 64'hF0F0_FFFF_0000_1234, 64'hFF00_0F0F_FFFF_00FF, 1'b1, "R10 AND");
    drive(6'h12, 64'h8000_0000_0000_0000, 64'd0, 1'b0, "R10 OR");
    drive(6'h13, 64'hAAAA_5555_AAAA_5555, 64'hAAAA_5555_AAAA_5555, 1'b0, "R10 XOR zero");
    drive(6'h15, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0F0F_0000_8000_0001, 1'b1, "R10 AND-NOT");
    drive(6'h16, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R10 OR-NOT");
    // unknown codes: R1
    drive(6'h17, 64'h1234, 64'h5678, 1'b1, "R1 unknown 0x17");
    drive(6'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, "R1 unknown 0x3F");
    drive(6'h0C, 64'd1, 64'd1, 1'b0, "R1 unknown 0x0C");
    // mixed patterns across all codes
    for (int i = 0; i < 300; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (i % 4 == 0) rb[31:0] = -ra[31:0];
      if (i % 7 == 0) rb = ra;
      drive(validOps[i % 9], ra, rb, 1'($urandom()), "R4 R7 R9 R10 mixed");
    end

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule